// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block works out the 16-bit effective address of one instruction operand for an 8-bit processor with a 16-bit address space. The caller gives a 4-bit mode code, the program counter that points at the first operand byte, the X and Y index values, a penalty-enable bit and a branch-taken bit, and pulses `start`. The sequencer then reads operand bytes and, for the indirect modes, pointer bytes through a byte-wide read port. The memory answers combinationally: `mem_rdata` belongs to the address on `mem_addr` in the same cycle.

When it finishes, the sequencer pulses `done` for one cycle. With that pulse it presents the effective address and the program counter advanced past the operand bytes. It also gives a page-cross flag and the number of extra cycles a taken relative branch costs. The sequencer keeps two behaviours that software relies on: zero-page indexing and zero-page pointer fetches wrap inside page zero, and the high byte of an indirect jump pointer is read from the same page as its low byte.

Top module: `idx_addr_seq`

## Requirements
- R1: Zero-page modes (code 0 plain, 1 plus X, 2 plus Y) give an address whose high byte is 0x00 and whose low byte is the operand plus the index, modulo 256.
- R2: Absolute modes plus X (code 4) and plus Y (code 5) give the little-endian 16-bit operand plus the index, modulo 65536. The page-cross flag is 1 when the operand low byte plus the index is above 0xFF and the penalty enable is 1.
- R3: Indexed-indirect (code 6) forms the pointer (operand + X) mod 256. It reads the low byte there and the high byte at (pointer + 1) mod 256, both in page zero, and the result is that 16-bit word.
- R4: Indirect-indexed (code 7) reads a little-endian word at the operand and at (operand + 1) mod 256 in page zero, and adds Y to it. The page-cross flag is 1 when the word's low byte plus Y is above 0xFF and the penalty enable is 1.
- R5: Indirect jump (code 8) reads the target low byte at the 16-bit operand pointer. It reads the high byte at the pointer with only its low byte incremented (no carry into the high byte).
- R6: Relative (code 9) gives the PC after the offset byte plus the sign-extended offset. The page-cross flag is 1 when the target's high byte differs from that PC's high byte, whatever the penalty enable or branch-taken bit. The extra-cycle output is 0 when not taken, 1 when taken within the page, and 2 when taken across a page.
- R7: Plain absolute (code 3) gives the little-endian operand word. In every mode `pc_out` is the input PC advanced by one for each operand byte read: one byte for codes 0,1,2,6,7,9 and two for codes 3,4,5,8.
- R8: With the penalty enable at 0, the page-cross flag stays 0 for codes 4, 5 and 7 even when the index carries out of the low byte.
- R9: Codes 10 to 15 read no operand and complete with the effective address and `pc_out` both equal to the input PC, the page-cross flag 0 and the extra-cycle output 0.
- R10: `done` is a single-cycle pulse that comes a fixed number of clock edges after the edge that samples `start`: 1 for codes 10-15, 2 for codes 0,1,2,9, 3 for codes 3,4,5, 4 for codes 6,7 and 5 for code 8.
- R11: While reset is low and after it is released, `done`, the page-cross flag, the extra-cycle output and the effective address are 0. A reset during a sequence ends it with no `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a sequence when idle; inputs below are sampled with it |
| mode | input | 4 | Addressing mode code |
| pc_in | input | 16 | Address of the first operand byte |
| x_idx | input | 8 | X index value |
| y_idx | input | 8 | Y index value |
| pen_en | input | 1 | Enables the page-cross flag for the indexed modes |
| br_taken | input | 1 | Branch condition for the relative mode |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data for mem_addr, same cycle |
| ea | output | 16 | Effective address, valid with done |
| pc_out | output | 16 | PC past the operand bytes, valid with done |
| page_cross | output | 1 | Page-cross flag, valid with done |
| br_extra | output | 2 | Extra cycles of a taken relative branch, valid with done |
| done | output | 1 | Single-cycle completion pulse |

## Verification
Each mode is run with indices that stay inside the low byte and with indices that carry out of it, so the sum and the page-cross flag are both tested. The penalty-enable bit is toggled on carrying cases, which shows it masks only the flag. Zero-page pointers placed at 0xFF, and an indirect-jump pointer at the end of a page, show page-zero wrap and the missing high-byte carry: the memory holds a different byte where a carried fetch would land. Relative offsets are tried forward and backward, taken and not, within and across pages, and the `done` latency and pulse width are measured for every mode.

// File: rtl/idx_addr_seq.sv
module idx_addr_seq #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [2*DW-1:0] pc_in,
  input  logic [DW-1:0]   x_idx,
  input  logic [DW-1:0]   y_idx,
  input  logic            pen_en,
  input  logic            br_taken,
  output logic [2*DW-1:0] mem_addr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] ea,
  output logic [2*DW-1:0] pc_out,
  output logic            page_cross,
  output logic [1:0]      br_extra,
  output logic            done
);
  localparam int AW = 2 * DW;
  localparam logic [3:0] M_ZPG = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
                         M_ABX = 4'd4, M_ABY = 4'd5, M_IDX = 4'd6, M_IDY = 4'd7,
                         M_IND = 4'd8, M_REL = 4'd9;

  typedef enum logic [2:0] {S_IDLE, S_OP0, S_OP1, S_PL, S_PH, S_FIN} st_t;
  st_t st;

  logic [3:0]    mode_r;
  logic [AW-1:0] pc_r;
  logic [DW-1:0] x_r, y_r, b0, b1, p_lo;
  logic          pen_r, tk_r;

  logic [AW-1:0] ea_q;
  logic          cross_q, done_q;
  logic [1:0]    extra_q;

  wire unused_md = (mode > M_REL);
  wire two_byte  = (mode_r == M_ABS) || (mode_r == M_ABX) || (mode_r == M_ABY) || (mode_r == M_IND);
  wire via_zp    = (mode_r == M_IDX) || (mode_r == M_IDY);
  wire use_y     = (mode_r == M_ZPY) || (mode_r == M_ABY) || (mode_r == M_IDY);

  wire [DW-1:0]   idx    = use_y ? y_r : x_r;
  wire [DW-1:0]   zp_ptr = (mode_r == M_IDX) ? b0 + x_r : b0;
  wire [DW:0]     lo_sum = {1'b0, b0} + {1'b0, idx};
  wire [AW-1:0]   base   = {b1, b0};
  wire [AW-1:0]   ix_ea  = base + {{DW{1'b0}}, idx};
  wire [AW-1:0]   rel_ea = pc_r + {{DW{b0[DW-1]}}, b0};
  wire            rel_pg = rel_ea[AW-1:DW] != pc_r[AW-1:DW];

  always_comb begin
    case (st)
      S_PL:    mem_addr = (mode_r == M_IND) ? base : {{DW{1'b0}}, zp_ptr};
      S_PH:    mem_addr = (mode_r == M_IND) ? {b1, b0 + 1'b1} : {{DW{1'b0}}, zp_ptr + 1'b1};
      default: mem_addr = pc_r;
    endcase
  end

  logic [AW-1:0] ea_c;
  logic          cross_c;
  logic [1:0]    extra_c;
  always_comb begin
    ea_c    = pc_r;
    cross_c = 1'b0;
    extra_c = 2'd0;
    case (mode_r)
      M_ZPG:                ea_c = {{DW{1'b0}}, b0};
      M_ZPX, M_ZPY:         ea_c = {{DW{1'b0}}, lo_sum[DW-1:0]};
      M_ABS, M_IDX, M_IND:  ea_c = base;
      M_ABX, M_ABY, M_IDY: begin
        ea_c    = ix_ea;
        cross_c = lo_sum[DW] & pen_r;
      end
      M_REL: begin
        ea_c    = rel_ea;
        cross_c = rel_pg;
        extra_c = tk_r ? (rel_pg ? 2'd2 : 2'd1) : 2'd0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_r  <= 4'd0;
      pc_r    <= '0;
      x_r     <= '0;
      y_r     <= '0;
      b0      <= '0;
      b1      <= '0;
      p_lo    <= '0;
      pen_r   <= 1'b0;
      tk_r    <= 1'b0;
      ea_q    <= '0;
      cross_q <= 1'b0;
      extra_q <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_r <= mode;
          pc_r   <= pc_in;
          x_r    <= x_idx;
          y_r    <= y_idx;
          pen_r  <= pen_en;
          tk_r   <= br_taken;
          st     <= unused_md ? S_FIN : S_OP0;
        end
        S_OP0: begin
          b0   <= mem_rdata;
          b1   <= '0;
          pc_r <= pc_r + 1'b1;
          st   <= two_byte ? S_OP1 : (via_zp ? S_PL : S_FIN);
        end
        S_OP1: begin
          b1   <= mem_rdata;
          pc_r <= pc_r + 1'b1;
          st   <= (mode_r == M_IND) ? S_PL : S_FIN;
        end
        S_PL: begin
          p_lo <= mem_rdata;
          st   <= S_PH;
        end
        S_PH: begin
          b1 <= mem_rdata;
          b0 <= p_lo;
          st <= S_FIN;
        end
        S_FIN: begin
          ea_q    <= ea_c;
          cross_q <= cross_c;
          extra_q <= extra_c;
          done_q  <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ea         = ea_q;
  assign pc_out     = pc_r;
  assign page_cross = cross_q;
  assign br_extra   = extra_q;
  assign done       = done_q;

  p_zp_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && (mode_r == M_ZPX || mode_r == M_ZPY) |-> ea_q[AW-1:DW] == '0);
  p_ptr_in_zp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PL || st == S_PH) && via_zp |-> mem_addr[AW-1:DW] == '0);
  p_same_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PH && mode_r == M_IND |-> mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]));
  p_extra_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && br_extra != 2'd0 |-> mode_r == M_REL);
  p_no_penalty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !pen_r && mode_r != M_REL |-> !page_cross);
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && mode_r > M_REL |-> ea == pc_out && !page_cross);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: tb/idx_addr_seq_tb.sv
module idx_addr_seq_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, pen_en, br_taken, done, page_cross;
  logic [3:0]  mode;
  logic [15:0] pc_in, mem_addr, ea, pc_out;
  logic [7:0]  x_idx, y_idx, mem_rdata;
  logic [1:0]  br_extra;

  idx_addr_seq dut_i (.clk, .rst_n, .start, .mode, .pc_in, .x_idx, .y_idx, .pen_en,
    .br_taken, .mem_addr, .mem_rdata, .ea, .pc_out, .page_cross, .br_extra, .done);

  logic [15:0] pa [4];
  logic [7:0]  pd [4];
  always_comb begin
    mem_rdata = 8'hEE;
    for (int i = 0; i < 4; i++) if (pa[i] == mem_addr) mem_rdata = pd[i];
  end

  typedef struct packed {
    logic [3:0] md; logic [15:0] pc; logic [7:0] x, y; logic pen, tk;
    logic [15:0] a0; logic [7:0] d0; logic [15:0] a1; logic [7:0] d1;
    logic [15:0] a2; logic [7:0] d2; logic [15:0] a3; logic [7:0] d3;
    logic [15:0] xea, xpc; logic xcr; logic [1:0] xex; logic [2:0] lat; logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{4'd1, 16'h0200, 8'h10, 8'h00, 1'b1, 1'b0, 16'h0200, 8'hF8, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0008, 16'h0201, 1'b0, 2'd0, 3'd2, 4'd1}, // R1
    '{4'd2, 16'h0300, 8'h00, 8'h05, 1'b1, 1'b0, 16'h0300, 8'h20, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0025, 16'h0301, 1'b0, 2'd0, 3'd2, 4'd1}, // R1
    '{4'd0, 16'h0400, 8'h33, 8'h44, 1'b1, 1'b0, 16'h0400, 8'h7F, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h007F, 16'h0401, 1'b0, 2'd0, 3'd2, 4'd7}, // R7
    '{4'd3, 16'h0500, 8'h33, 8'h44, 1'b1, 1'b0, 16'h0500, 8'h34, 16'h0501, 8'h12, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h1234, 16'h0502, 1'b0, 2'd0, 3'd3, 4'd7}, // R7
    '{4'd4, 16'h0600, 8'h10, 8'h00, 1'b1, 1'b0, 16'h0600, 8'h20, 16'h0601, 8'h30, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h3030, 16'h0602, 1'b0, 2'd0, 3'd3, 4'd2}, // R2
    '{4'd4, 16'h0610, 8'h80, 8'h00, 1'b1, 1'b0, 16'h0610, 8'hF0, 16'h0611, 8'h30, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h3170, 16'h0612, 1'b1, 2'd0, 3'd3, 4'd2}, // R2
    '{4'd5, 16'h0620, 8'h00, 8'h01, 1'b0, 1'b0, 16'h0620, 8'hFF, 16'h0621, 8'h30, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h3100, 16'h0622, 1'b0, 2'd0, 3'd3, 4'd8}, // R8
    '{4'd5, 16'h0630, 8'h00, 8'h02, 1'b1, 1'b0, 16'h0630, 8'hFF, 16'h0631, 8'hFF, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0001, 16'h0632, 1'b1, 2'd0, 3'd3, 4'd2}, // R2
    '{4'd6, 16'h0700, 8'h04, 8'h00, 1'b1, 1'b0, 16'h0700, 8'h10, 16'h0014, 8'hCD, 16'h0015, 8'hAB, 16'hFFFF, 8'hEE, 16'hABCD, 16'h0701, 1'b0, 2'd0, 3'd4, 4'd3}, // R3
    '{4'd6, 16'h0710, 8'h01, 8'h00, 1'b1, 1'b0, 16'h0710, 8'hFE, 16'h00FF, 8'h78, 16'h0000, 8'h56, 16'h0100, 8'h99, 16'h5678, 16'h0711, 1'b0, 2'd0, 3'd4, 4'd3}, // R3
    '{4'd7, 16'h0800, 8'h00, 8'h10, 1'b1, 1'b0, 16'h0800, 8'h40, 16'h0040, 8'hF8, 16'h0041, 8'h12, 16'hFFFF, 8'hEE, 16'h1308, 16'h0801, 1'b1, 2'd0, 3'd4, 4'd4}, // R4
    '{4'd7, 16'h0810, 8'h00, 8'h05, 1'b1, 1'b0, 16'h0810, 8'h42, 16'h0042, 8'h00, 16'h0043, 8'h20, 16'hFFFF, 8'hEE, 16'h2005, 16'h0811, 1'b0, 2'd0, 3'd4, 4'd4}, // R4
    '{4'd7, 16'h0820, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0820, 8'hFF, 16'h00FF, 8'h11, 16'h0000, 8'h22, 16'h0100, 8'h99, 16'h2211, 16'h0821, 1'b0, 2'd0, 3'd4, 4'd4}, // R4
    '{4'd7, 16'h0830, 8'h00, 8'hFF, 1'b0, 1'b0, 16'h0830, 8'h44, 16'h0044, 8'h01, 16'h0045, 8'h40, 16'hFFFF, 8'hEE, 16'h4100, 16'h0831, 1'b0, 2'd0, 3'd4, 4'd8}, // R8
    '{4'd8, 16'h0900, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0900, 8'hFF, 16'h0901, 8'h30, 16'h30FF, 8'h80, 16'h3000, 8'h50, 16'h5080, 16'h0902, 1'b0, 2'd0, 3'd5, 4'd5}, // R5
    '{4'd8, 16'h0910, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0910, 8'h40, 16'h0911, 8'h20, 16'h2040, 8'h00, 16'h2041, 8'hC0, 16'hC000, 16'h0912, 1'b0, 2'd0, 3'd5, 4'd5}, // R5
    '{4'd9, 16'h0A00, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0A00, 8'h10, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0A11, 16'h0A01, 1'b0, 2'd0, 3'd2, 4'd6}, // R6
    '{4'd9, 16'h0A20, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0A20, 8'hF0, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0A11, 16'h0A21, 1'b0, 2'd1, 3'd2, 4'd6}, // R6
    '{4'd9, 16'h0AF0, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0AF0, 8'h20, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0B11, 16'h0AF1, 1'b1, 2'd2, 3'd2, 4'd6}, // R6
    '{4'd9, 16'h0B02, 8'h00, 8'h00, 1'b0, 1'b1, 16'h0B02, 8'h80, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0A83, 16'h0B03, 1'b1, 2'd2, 3'd2, 4'd6}, // R6
    '{4'd9, 16'h0AF0, 8'h00, 8'h00, 1'b1, 1'b0, 16'h0AF0, 8'h20, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h0B11, 16'h0AF1, 1'b1, 2'd0, 3'd2, 4'd6}, // R6
    '{4'd12, 16'h1234, 8'h11, 8'h22, 1'b1, 1'b1, 16'h1234, 8'h55, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'h1234, 16'h1234, 1'b0, 2'd0, 3'd1, 4'd9}, // R9
    '{4'd15, 16'hBEEF, 8'hFF, 8'hFF, 1'b1, 1'b1, 16'hBEEF, 8'hFF, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hFFFF, 8'hEE, 16'hBEEF, 16'hBEEF, 1'b0, 2'd0, 3'd1, 4'd9}  // R9
  };

  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input int n);
    int cnt;
    pa[0] = v.a0; pd[0] = v.d0; pa[1] = v.a1; pd[1] = v.d1;
    pa[2] = v.a2; pd[2] = v.d2; pa[3] = v.a3; pd[3] = v.d3;
    @(negedge clk);
    mode = v.md; pc_in = v.pc; x_idx = v.x; y_idx = v.y; pen_en = v.pen; br_taken = v.tk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode = 4'd0; pc_in = 16'h0; x_idx = 8'h0; y_idx = 8'h0; pen_en = 1'b0; br_taken = 1'b0;
    cnt = 0;
    while (!done && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == int'(v.lat), $sformatf("R10 latency vec%0d", n), cnt, v.lat);
    chk(ea == v.xea, $sformatf("R%0d ea vec%0d", v.req, n), ea, v.xea);
    chk(pc_out == v.xpc, $sformatf("R7 pc_out vec%0d", n), pc_out, v.xpc);
    chk(page_cross == v.xcr, $sformatf("R%0d page_cross vec%0d", v.req, n), page_cross, v.xcr);
    chk(br_extra == v.xex, $sformatf("R%0d br_extra vec%0d", v.req, n), br_extra, v.xex);
    @(negedge clk);
    chk(!done, $sformatf("R10 done width vec%0d", n), done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin pa[i] = 16'hFFFF; pd[i] = 8'hEE; end
    rst_n = 1'b0; start = 1'b0; mode = 4'd0; pc_in = 16'h0;
    x_idx = 8'h0; y_idx = 8'h0; pen_en = 1'b0; br_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!done, "R11 done after reset", done, 0);
    chk(!page_cross, "R11 page_cross after reset", page_cross, 0);
    chk(br_extra == 2'd0, "R11 br_extra after reset", br_extra, 0);
    chk(ea == 16'h0, "R11 ea after reset", ea, 0);

    for (int n = 0; n < NV; n++) run(VT[n], n);

    // R11 reset in the middle of an indirect jump sequence
    pa[0] = 16'h0900; pd[0] = 8'hFF; pa[1] = 16'h0901; pd[1] = 8'h30;
    @(negedge clk);
    mode = 4'd8; pc_in = 16'h0900; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (k == 1) rst_n = 1'b1;
        if (done) seen = 1'b1;
      end
      chk(!seen, "R11 no done after mid-sequence reset", seen, 0);
    end
    chk(ea == 16'h0, "R11 ea cleared by mid-sequence reset", ea, 0);
    run(VT[14], 14);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule